// File: doc/BRIEF.md
# Transmit Word Phase-Decoupling FIFO

This block carries 16-bit words from an externally supplied word clock into an internally generated word clock. Both clocks run at the same frequency but their phase relation is unknown. Words go into an 8-entry ring on every rising edge of the external clock. The internal clock reads one word per edge and hands it to the serializer.

The ring has to be centered before its output is trusted. Centering starts when lock detect comes up, either at power-up or after a reset once lock returns, or when the phase-init input rises. It only takes effect on the third external-clock edge after the trigger, so the external clock is settled before the pointers move. The read side then places its pointer so that the write pointer, as seen through the read-domain synchronizer, leads it by 4 entries. A monitor keeps comparing that synchronized separation against the hazard limits. When the two domains drift close to a setup or hold problem, it raises a phase-error flag, and the flag stays up until a realignment has finished. Tying the flag back to phase-init gives automatic recovery, at the cost of a few discarded words.

Top module: `txword_phase_fifo`

## Requirements
- R1: While `rst_n` is low, `dout` is all zeros and `phase_err` is low. Reset acts at once, without waiting for a clock edge.
- R2: Once centered and with equal clock frequencies, every rising `wclk` edge captures `din`. `dout` then delivers those words in write order with no gap and no repeat. Each word appears a constant 4 to 9 write periods after it was written.
- R3: A rising `lock_det` starts centering, and so does the return of lock after a reset. Centering completes on the third `wclk` edge after the synchronized trigger. In the bench's clock arrangement, the first non-zero word appears on the 9th to 12th read-clock sample after `lock_det` rises.
- R4: A rising `phase_init` that is held for at least 2 read-clock periods recenters the ring. At most 10 written words are skipped between the last word before the realignment and the first word after it.
- R5: While realignment is in progress, including before the first centering, `dout` is all zeros.
- R6: When `lock_det` is low, `dout` goes to zeros within 4 read-clock edges and stays there. It stays zero until lock returns and centering completes.
- R7: `phase_err` rises when the synchronized separation, write pointer minus read pointer modulo 8, falls to 1. This is the case where the read clock runs fast.
- R8: `phase_err` rises when the synchronized separation reaches 7. This is the case where the read clock runs slow.
- R9: `phase_err` stays high until a realignment completes. It is low again by the first word delivered after that realignment.
- R10: After centering, with clocks of equal frequency, `phase_err` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | External word clock; data captured on its rising edge |
| din | input | 16 | Word from the upstream logic |
| rclk | input | 1 | Internal word clock (serial clock divided by 16) |
| lock_det | input | 1 | Clock synthesizer lock indication, active high |
| phase_init | input | 1 | Realignment request; rising edge acts, hold for at least 2 `rclk` periods |
| rst_n | input | 1 | Asynchronous active-low reset of both clock domains |
| dout | output | 16 | Word to the serializer; zero while realigning |
| phase_err | output | 1 | Phase hazard flag, held until realignment completes |

## Verification
The hardest state to reach is a pointer separation that has slid to the hazard limits of 1 or 7. With equal clock periods this never happens. To get there, the bench shortens or stretches the read-clock period by a fraction of a nanosecond until the separation creeps to a limit and the flag rises. It then restores the period and drives phase-init, as the intended recovery wiring would. The reference model stops its continuity checks while drift is in progress. Once the realignment has completed, it resumes them and checks both the number of words skipped and the return of a constant latency.

// File: rtl/txpf_pkg.sv
package txpf_pkg;
  localparam int unsigned PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t to_gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(input ptr_t g);
    ptr_t b;
    b = g;
    for (int i = 1; i < int'(PTR_MAX); i++) b = b ^ (g >> i);
    return b;
  endfunction

  // separation of two ring pointers, depth a power of two
  function automatic ptr_t ring_gap(input ptr_t ahead, input ptr_t behind,
                                    input int unsigned depth);
    return (ahead - behind) & ptr_t'(depth - 1);
  endfunction

  function automatic logic near_edge(input int unsigned gap, input int unsigned depth,
                                     input int unsigned margin);
    return (gap == margin) || (gap == depth - margin);
  endfunction
endpackage

// File: rtl/txpf_sync.sv
module txpf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/txpf_wrside.sv
module txpf_wrside #(
  parameter int DEPTH        = 8,
  parameter int SETTLE_EDGES = 3,
  parameter int SYNC_STAGES  = 2,
  localparam int PW          = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          lock_in,
  input  logic          pinit_in,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] wr_gray,
  output logic          center_tgl,
  output logic          req_w,
  output logic          center_w
);
  import txpf_pkg::*;
  localparam int CW = $clog2(SETTLE_EDGES + 1);

  logic [1:0]    ctl_s;
  logic          lock_s, pinit_s, lock_q, pinit_q;
  logic [CW-1:0] settle_cnt;

  txpf_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(wclk), .rst_n(rst_n), .d({lock_in, pinit_in}), .q(ctl_s)
  );
  assign lock_s  = ctl_s[1];
  assign pinit_s = ctl_s[0];

  // trigger: lock just arrived, or a fresh init request while locked
  assign req_w    = lock_s & (!lock_q | (pinit_s & !pinit_q));
  assign center_w = (settle_cnt == CW'(1)) & !req_w;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      pinit_q    <= 1'b0;
      settle_cnt <= '0;
      wr_ptr     <= '0;
      wr_gray    <= '0;
      center_tgl <= 1'b0;
    end else begin
      lock_q  <= lock_s;
      pinit_q <= pinit_s;
      wr_ptr  <= wr_ptr + 1'b1;
      wr_gray <= PW'(to_gray(ptr_t'(wr_ptr + 1'b1)));
      if (!lock_s)               settle_cnt <= '0;
      else if (req_w)            settle_cnt <= CW'(SETTLE_EDGES);
      else if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
      if (center_w) center_tgl <= ~center_tgl;
    end
  end
endmodule

// File: rtl/txpf_store.sv
module txpf_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic [PW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] slots [DEPTH];

  always_ff @(posedge wclk) slots[waddr] <= wdata;

  assign rdata = slots[raddr];
endmodule

// File: rtl/txpf_rdside.sv
module txpf_rdside #(
  parameter int WORD_W      = 16,
  parameter int DEPTH       = 8,
  parameter int CENTER      = 4,
  parameter int HAZARD_GAP  = 1,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = $clog2(DEPTH)
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              lock_in,
  input  logic              pinit_in,
  input  logic              center_tgl_in,
  input  logic [PW-1:0]     wgray_in,
  input  logic [WORD_W-1:0] slot_data,
  output logic [PW-1:0]     rd_ptr,
  output logic [WORD_W-1:0] dout,
  output logic              phase_err,
  output logic              realign,
  output logic              done_r,
  output logic              hazard,
  output logic              lock_s
);
  import txpf_pkg::*;
  // loading ptr = wsync - (CENTER-1) gives a gap of CENTER one edge later
  localparam logic [PW-1:0] LOAD_OFS = PW'(CENTER - 1);

  logic [2:0]    ctl_s;
  logic          pinit_s, pinit_q, tgl_s, tgl_q, commit;
  logic [PW-1:0] wgray_s, wbin, gap;

  txpf_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(rclk), .rst_n(rst_n), .d({lock_in, pinit_in, center_tgl_in}), .q(ctl_s)
  );
  txpf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_ptr_sync (
    .clk(rclk), .rst_n(rst_n), .d(wgray_in), .q(wgray_s)
  );
  assign lock_s  = ctl_s[2];
  assign pinit_s = ctl_s[1];
  assign tgl_s   = ctl_s[0];

  assign done_r = tgl_s ^ tgl_q;
  assign commit = done_r & lock_s;
  assign wbin   = PW'(from_gray(ptr_t'(wgray_s)));
  assign gap    = PW'(ring_gap(ptr_t'(wbin), ptr_t'(rd_ptr), DEPTH));
  assign hazard = !realign && near_edge(32'(gap), DEPTH, HAZARD_GAP);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q     <= 1'b0;
      pinit_q   <= 1'b0;
      realign   <= 1'b1;
      rd_ptr    <= '0;
      phase_err <= 1'b0;
      dout      <= '0;
    end else begin
      tgl_q   <= tgl_s;
      pinit_q <= pinit_s;
      if (commit)                            realign <= 1'b0;
      else if (!lock_s || (pinit_s && !pinit_q)) realign <= 1'b1;
      rd_ptr <= commit ? (wbin - LOAD_OFS) : (rd_ptr + 1'b1);
      if (commit)      phase_err <= 1'b0;
      else if (hazard) phase_err <= 1'b1;
      dout <= realign ? '0 : slot_data;
    end
  end
endmodule

// File: rtl/txword_phase_fifo.sv
module txword_phase_fifo #(
  parameter int WORD_W       = 16,
  parameter int DEPTH        = 8,
  parameter int SETTLE_EDGES = 3,
  parameter int HAZARD_GAP   = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              wclk,
  input  logic [WORD_W-1:0] din,
  input  logic              rclk,
  input  logic              lock_det,
  input  logic              phase_init,
  input  logic              rst_n,
  output logic [WORD_W-1:0] dout,
  output logic              phase_err
);
  localparam int PW     = $clog2(DEPTH);
  localparam int CENTER = DEPTH / 2;

  logic [PW-1:0]     wr_ptr, wr_gray, rd_ptr;
  logic [WORD_W-1:0] slot_data;
  logic              center_tgl, req_w, center_w;
  logic              rd_realign, done_r, hazard, lock_rs;

  txpf_wrside #(.DEPTH(DEPTH), .SETTLE_EDGES(SETTLE_EDGES), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .lock_in(lock_det), .pinit_in(phase_init),
    .wr_ptr(wr_ptr), .wr_gray(wr_gray), .center_tgl(center_tgl),
    .req_w(req_w), .center_w(center_w)
  );

  txpf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .wclk(wclk), .waddr(wr_ptr), .wdata(din), .raddr(rd_ptr), .rdata(slot_data)
  );

  txpf_rdside #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CENTER(CENTER),
                .HAZARD_GAP(HAZARD_GAP), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .lock_in(lock_det), .pinit_in(phase_init),
    .center_tgl_in(center_tgl), .wgray_in(wr_gray), .slot_data(slot_data),
    .rd_ptr(rd_ptr), .dout(dout), .phase_err(phase_err), .realign(rd_realign),
    .done_r(done_r), .hazard(hazard), .lock_s(lock_rs)
  );
endmodule

// File: rtl/txword_phase_fifo_chk.sv
module txword_phase_fifo_chk #(
  parameter int WORD_W = 16
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic [WORD_W-1:0] dout,
  input logic              phase_err,
  input logic              realign,
  input logic              done_r,
  input logic              hazard,
  input logic              lock_s,
  input logic              req_w,
  input logic              center_w
);
  // R5: a realigning read side delivers zeros on the next edge
  assert_zero_while_realign_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    realign |=> (dout == '0));

  // R6: lost lock forces realignment
  assert_unlock_realigns_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    !lock_s |=> realign);

  // R7 / R8: the flag only rises after a detected hazard
  assert_err_needs_hazard_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    $rose(phase_err) |-> $past(hazard));

  // R9: the flag only falls when a realignment completes
  assert_err_clears_on_done_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(phase_err) |-> $past(done_r));

  // R3: centering never fires within two edges of its trigger
  assert_third_edge_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    center_w |-> (!$past(req_w) && !$past(req_w, 2)));
endmodule

bind txword_phase_fifo txword_phase_fifo_chk #(.WORD_W(WORD_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .dout(dout), .phase_err(phase_err),
  .realign(rd_realign), .done_r(done_r), .hazard(hazard), .lock_s(lock_rs),
  .req_w(req_w), .center_w(center_w)
);

// File: tb/txword_phase_fifo_bench.sv
`timescale 1ns/1ps
module txword_phase_fifo_bench;
  logic        wclk, rclk, rst_n, lock_det, phase_init, phase_err;
  logic [15:0] din, dout;

  txword_phase_fifo u_txword_phase_fifo (
    .wclk(wclk), .din(din), .rclk(rclk), .lock_det(lock_det), .phase_init(phase_init),
    .rst_n(rst_n), .dout(dout), .phase_err(phase_err)
  );

  int checks = 0, errors = 0;
  realtime rd_half = 2.0;
  bit done_flag = 0;

  initial begin wclk = 0; forever #2 wclk = ~wclk; end
  initial begin
    rclk = 0; #1.3;
    forever begin rclk = 1; #(rd_half); rclk = 0; #(rd_half); end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- write side stimulus and history ----------------
  int          wcount = 0;
  logic [15:0] mask = 16'h0000;
  logic [15:0] hist [64];

  function automatic logic [15:0] word_of(input int i, input logic [15:0] m);
    return 16'h8000 | ((16'(i) ^ m) & 16'h7fff);
  endfunction

  initial din = word_of(0, 16'h0000);
  always @(negedge wclk) din <= word_of(wcount, mask);
  always @(posedge wclk) begin hist[wcount % 64] = din; wcount++; end

  function automatic int find_word(input logic [15:0] w);
    for (int j = 1; j <= 24; j++)
      if (wcount - j >= 0 && hist[(wcount - j) % 64] == w) return wcount - j;
    return -1;
  endfunction

  // ---------------- reference model on the read side ----------------
  bit   cont_on = 0, steady = 0;
  int   prev_idx = -1, lag_ref = -1, last_nz = -1, zero_run = 0, resumes = 0, lost = -1;
  int   idx, lag;
  logic [15:0] s_dout, expw;
  logic s_err;
  event sampled;

  always @(posedge rclk) begin
    #1;
    s_dout = dout;
    s_err  = phase_err;
    if (s_dout == 16'h0) begin
      prev_idx = -1; lag_ref = -1; zero_run++;
    end else begin
      idx = -1;
      if (prev_idx >= 0 && prev_idx + 1 < wcount) begin
        expw = hist[(prev_idx + 1) % 64];
        if (cont_on) check(s_dout == expw, "R2 word order", {16'h0, s_dout}, {16'h0, expw});
        if (s_dout == expw) idx = prev_idx + 1;
      end
      if (idx < 0) idx = find_word(s_dout);
      if (cont_on) check(idx >= 0, "R2 word was written", {16'h0, s_dout}, 32'h0);
      if (idx >= 0 && cont_on && steady) begin
        lag = wcount - idx;
        if (lag_ref < 0) begin
          lag_ref = lag;
          check(lag >= 4 && lag <= 9, "R2 latency range", lag, 7);
        end else check(lag == lag_ref, "R2 constant latency", lag, lag_ref);
      end
      if (zero_run > 0) begin
        lost = (last_nz >= 0 && idx >= 0) ? idx - last_nz - 1 : -1;
        resumes++;
      end
      zero_run = 0;
      last_nz  = idx;
      prev_idx = idx;
    end
    if (steady) check(!s_err, "R10 no phase error", s_err, 0);
    -> sampled;
  end

  task automatic wait_samples(input int n);
    repeat (n) @(sampled);
  endtask

  task automatic wait_resume(input int limit, output int n);
    int r0 = resumes;
    n = 0;
    while (resumes == r0 && n < limit) begin @(sampled); n++; end
  endtask

  task automatic recenter_from_error(input string tag);
    int n;
    rd_half = 2.0;
    wait_samples(1);
    phase_init = 1;
    wait_samples(3);
    phase_init = 0;
    wait_samples(1);
    check(s_err == 1'b1, {tag, " R9 flag held during realignment"}, s_err, 1);
    wait_resume(40, n);
    check(n < 40, {tag, " R4 data resumes after request"}, n, 10);
    check(s_err == 1'b0, "R9 flag low at first word after realignment", s_err, 0);
    cont_on = 1; steady = 1;
    wait_samples(80);
  endtask

  // ---------------- sequence ----------------
  initial begin
    int n;
    rst_n = 0; lock_det = 0; phase_init = 0;
    wait_samples(5);
    for (int i = 0; i < 4; i++) begin
      @(sampled);
      check(s_dout == 16'h0, "R1 reset data", s_dout, 0);
      check(s_err == 1'b0, "R1 reset flag", s_err, 0);
    end
    rst_n = 1;
    for (int i = 0; i < 30; i++) begin
      @(sampled);
      check(s_dout == 16'h0, "R5 zeros before first centering", s_dout, 0);
    end

    // power-up lock
    lock_det = 1;
    wait_resume(30, n);
    check(n >= 9 && n <= 12, "R3 centering after lock on third edge", n, 10);
    cont_on = 1; steady = 1;
    wait_samples(100);
    mask = 16'h2a5c;
    wait_samples(100);

    // explicit realignment request
    phase_init = 1;
    wait_samples(3);
    phase_init = 0;
    wait_resume(40, n);
    check(n >= 5 && n < 40, "R4 recenter on request", n, 10);
    check(lost >= 0 && lost <= 10, "R4 words lost", lost, 6);
    wait_samples(100);

    // read clock fast: separation shrinks to the lower limit
    cont_on = 0; steady = 0; mask = 16'h5193;
    rd_half = 1.9537;
    n = 0;
    while (!s_err && n < 800) begin @(sampled); n++; end
    check(s_err == 1'b1, "R7 flag on small separation", s_err, 1);
    recenter_from_error("fast");

    // read clock slow: separation grows to the upper limit
    cont_on = 0; steady = 0; mask = 16'h0ff0;
    rd_half = 2.0463;
    n = 0;
    while (!s_err && n < 800) begin @(sampled); n++; end
    check(s_err == 1'b1, "R8 flag on large separation", s_err, 1);
    recenter_from_error("slow");

    // lock loss and return
    steady = 0;
    lock_det = 0;
    wait_samples(4);
    check(s_dout == 16'h0, "R6 zeros after lock loss", s_dout, 0);
    for (int i = 0; i < 20; i++) begin
      @(sampled);
      check(s_dout == 16'h0, "R6 zeros while unlocked", s_dout, 0);
    end
    lock_det = 1;
    wait_resume(30, n);
    check(n >= 9 && n <= 12, "R3 centering after lock return", n, 10);
    steady = 1;
    wait_samples(60);

    // mid-run reset
    steady = 0;
    rst_n = 0; lock_det = 0;
    #0.5;
    check(dout == 16'h0, "R1 asynchronous clear", dout, 0);
    wait_samples(3);
    check(s_dout == 16'h0 && s_err == 1'b0, "R1 held in reset", {s_err, s_dout}, 0);
    rst_n = 1;
    wait_samples(5);
    lock_det = 1;
    wait_resume(30, n);
    check(n >= 9 && n <= 12, "R3 centering after reset recovery", n, 10);
    steady = 1;
    wait_samples(60);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule